// File: doc/BRIEF.md
# Debug Data Transfer Handshake Controller

This block sits between an external debugger bus and a processor core. It moves words through three registers: a receive register that the debugger fills and the core drains, a transmit register that the core fills and the debugger drains, and an instruction register that the debugger loads for the core to fetch. Full and instruction-complete flags govern every transfer. Each of these flags has a live copy and a latched copy. The latched copy is refreshed when the debugger reads the status word.

A 2-bit mode field sets the flow control on the debugger port only. In non-blocking mode (code 00, the reset value), an access whose latched flag is not ready has no effect. In stall mode (01), the bus ready signal stays low until the core-side event that makes the access possible. Fast mode (10) stalls in the same way. In addition, every successful receive write or transmit read in fast mode issues an instruction fetch. Core-side strobes are never delayed or dropped.

Top module: `dbg_xfer_ctrl`

## Requirements
- R1: After reset the receive-full and transmit-full flags and their latched copies are 0, the instruction-complete flag and its latched copy are 1, and the mode is 00. `pready` is 1 and `instr_fetch` is 0, so the status word reads 0x24.
- R2: The debugger address map is 0 status/control, 1 receive, 2 transmit, 3 instruction. The status word has these bits: [0] receive-full, [1] transmit-full, [2] instruction-complete, [3] latched receive-full, [4] latched transmit-full, [5] latched instruction-complete, [7:6] mode. A debugger write to address 0 loads the mode from bits [7:6]. The reserved code 11 is ignored, and the previous mode is kept.
- R3: A debugger status read returns the values held before the read. It then copies the three live flags into their latched copies.
- R4: In mode 00, a debugger receive write is dropped when latched receive-full is 1, and the data and flags stay unchanged. A successful receive write stores the data and sets both receive-full flags.
- R5: In mode 00, a debugger transmit read is dropped when latched transmit-full is 0, and the flags stay unchanged. A successful read returns the transmit data and clears both transmit-full flags.
- R6: In mode 00, a debugger instruction write is dropped while latched instruction-complete is 0. On a successful write the word is stored, both instruction-complete flags clear, and `instr_fetch` pulses for exactly one cycle on the next cycle. Every fetch clears both instruction-complete flags.
- R7: In modes 01 and 10, three accesses hold `pready` low with no timeout: a receive write waits while receive-full is 1, a transmit read waits while transmit-full is 0, and an instruction write waits while instruction-complete is 0. `pready` rises in the same cycle as the releasing core event (`cpu_rx_rd`, `cpu_tx_wr` or `instr_done`). A transmit read released this way returns `cpu_tx_wdata`.
- R8: In mode 10, each successful receive write or transmit read also produces a fetch pulse. In modes 00 and 01, only instruction writes fetch.
- R9: `cpu_rx_rd` clears receive-full. `cpu_tx_wr` stores `cpu_tx_wdata` and sets transmit-full, and overwrites the data if the flag is already set. Neither strobe is affected by the mode.
- R10: `instr_done` sets instruction-complete. `halt_enter` sets latched instruction-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Debugger bus select |
| penable | input | 1 | Debugger bus access phase |
| pwrite | input | 1 | Debugger bus write |
| paddr | input | 2 | Register address |
| pwdata | input | DATA_W | Debugger write data |
| prdata | output | DATA_W | Debugger read data |
| pready | output | 1 | Low while an access is stalled |
| cpu_rx_rd | input | 1 | Core reads receive register |
| cpu_rx_data | output | DATA_W | Receive register contents |
| cpu_tx_wr | input | 1 | Core writes transmit register |
| cpu_tx_wdata | input | DATA_W | Core transmit data |
| instr_fetch | output | 1 | One-cycle instruction fetch request |
| instr_word | output | DATA_W | Instruction register contents |
| instr_done | input | 1 | Core finished the fetched instruction |
| halt_enter | input | 1 | Core entered halting debug state |

## Verification
The bench builds the block with an 8-bit data width. With that width the whole status word fits in one byte, and the receive path can be swept over sixteen distinct data patterns, each followed by the status read that re-arms the latched flag. All three mode codes and the reserved code are driven. Each of the three stall conditions is released by its own core strobe, and the bench confirms that `pready` rises in that same cycle.

// File: rtl/dbg_xfer_ctrl.sv
module dbg_xfer_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [1:0]        paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              cpu_rx_rd,
  output logic [DATA_W-1:0] cpu_rx_data,
  input  logic              cpu_tx_wr,
  input  logic [DATA_W-1:0] cpu_tx_wdata,
  output logic              instr_fetch,
  output logic [DATA_W-1:0] instr_word,
  input  logic              instr_done,
  input  logic              halt_enter
);
  localparam logic [1:0] A_CTL = 2'd0, A_RX = 2'd1, A_TX = 2'd2, A_IT = 2'd3;
  localparam logic [1:0] M_NB = 2'd0, M_STALL = 2'd1, M_FAST = 2'd2, M_RSVD = 2'd3;

  logic [1:0]        mode;
  logic              rx_full, tx_full, ic, rx_l, tx_l, ic_l;
  logic [DATA_W-1:0] rx_data, tx_data;
  logic [7:0]        status;

  wire blocking = (mode == M_STALL) || (mode == M_FAST);
  wire nb       = (mode == M_NB);
  wire rx_wait  = pwrite  && paddr == A_RX && rx_full && !cpu_rx_rd;
  wire tx_wait  = !pwrite && paddr == A_TX && !tx_full && !cpu_tx_wr;
  wire it_wait  = pwrite  && paddr == A_IT && !ic && !instr_done;
  assign pready = !(psel && blocking && (rx_wait || tx_wait || it_wait));

  wire acc      = psel && penable && pready;
  wire stat_rd  = acc && !pwrite && paddr == A_CTL;
  wire ctl_wr   = acc && pwrite && paddr == A_CTL;
  wire rx_wr_ok = acc && pwrite && paddr == A_RX && !(nb && rx_l);
  wire tx_rd_ok = acc && !pwrite && paddr == A_TX && !(nb && !tx_l);
  wire it_wr_ok = acc && pwrite && paddr == A_IT && !(nb && !ic_l);
  wire fetch    = it_wr_ok || (mode == M_FAST && (rx_wr_ok || tx_rd_ok));

  assign status      = {mode, ic_l, tx_l, rx_l, ic, tx_full, rx_full};
  assign cpu_rx_data = rx_data;

  always_comb begin
    prdata = '0;
    case (paddr)
      A_CTL:   prdata[7:0] = status;
      A_RX:    prdata = rx_data;
      A_TX:    prdata = cpu_tx_wr ? cpu_tx_wdata : tx_data;
      default: prdata = instr_word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_NB;
      rx_full     <= 1'b0;
      tx_full     <= 1'b0;
      ic          <= 1'b1;
      rx_l        <= 1'b0;
      tx_l        <= 1'b0;
      ic_l        <= 1'b1;
      rx_data     <= '0;
      tx_data     <= '0;
      instr_word  <= '0;
      instr_fetch <= 1'b0;
    end else begin
      instr_fetch <= fetch;
      if (ctl_wr && pwdata[7:6] != M_RSVD) mode <= pwdata[7:6];

      if (rx_wr_ok) begin
        rx_data <= pwdata;
        rx_full <= 1'b1;
      end else if (cpu_rx_rd) rx_full <= 1'b0;
      if (rx_wr_ok) rx_l <= 1'b1;
      else if (stat_rd) rx_l <= rx_full;

      if (cpu_tx_wr) tx_data <= cpu_tx_wdata;
      if (tx_rd_ok) tx_full <= 1'b0;
      else if (cpu_tx_wr) tx_full <= 1'b1;
      if (tx_rd_ok) tx_l <= 1'b0;
      else if (stat_rd) tx_l <= tx_full;

      if (it_wr_ok) instr_word <= pwdata;
      if (fetch) ic <= 1'b0;
      else if (instr_done) ic <= 1'b1;
      if (fetch) ic_l <= 1'b0;
      else if (halt_enter) ic_l <= 1'b1;
      else if (stat_rd) ic_l <= ic;
    end
  end

  // R4
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && pwrite && paddr == A_RX && !(mode == M_NB && rx_l))
      |=> (rx_full && rx_l));

  // R4
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pwrite && paddr == A_RX && mode == M_NB && rx_l)
      |=> $stable(rx_data));

  // R5
  tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && !pwrite && paddr == A_TX && !(mode == M_NB && !tx_l))
      |=> (!tx_full && !tx_l));

  // R6
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_fetch |=> !instr_fetch);

  // R6
  fetch_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(instr_fetch) |-> (!ic && !ic_l));

  // R9
  cpu_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rx_rd && !(psel && penable && pwrite && paddr == A_RX)) |=> !rx_full);

  // R10
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_enter && !(psel && penable)) |=> ic_l);
endmodule

// File: tb/sim_dbg_xfer_ctrl.sv
module sim_dbg_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [1:0] paddr = 0;
  logic [DW-1:0] pwdata = 0, prdata, cpu_rx_data, cpu_tx_wdata = 0, instr_word;
  logic pready, cpu_rx_rd = 0, cpu_tx_wr = 0, instr_fetch, instr_done = 0, halt_enter = 0;

  int nchk = 0, nerr = 0, fetch_cnt = 0, wide = 0, base;
  logic prev_fetch = 0;
  logic [DW-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_xfer_ctrl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .cpu_rx_rd(cpu_rx_rd), .cpu_rx_data(cpu_rx_data), .cpu_tx_wr(cpu_tx_wr),
    .cpu_tx_wdata(cpu_tx_wdata), .instr_fetch(instr_fetch), .instr_word(instr_word),
    .instr_done(instr_done), .halt_enter(halt_enter));

  always @(posedge clk) begin
    if (instr_fetch) fetch_cnt <= fetch_cnt + 1;
    if (instr_fetch && prev_fetch) wide <= wide + 1;
    prev_fetch <= instr_fetch;
  end

  function automatic logic [7:0] stv(input logic rx, tx, ic, rxl, txl, icl, input logic [1:0] m);
    return {m, icl, txl, rxl, ic, tx, rx};
  endfunction

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", r, a, e);
    end
  endtask

  task automatic apb(input logic wr, input logic [1:0] a, input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk); psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    #1;
    while (!pready) begin @(negedge clk); #1; end
    q = prdata;
    @(posedge clk); #1; psel = 0; penable = 0;
  endtask

  task automatic stat(input string r, input logic [7:0] e);
    logic [DW-1:0] q;
    apb(0, 2'd0, '0, q);
    chk(r, q, e);
  endtask

  task automatic strobe(input int which, input logic [DW-1:0] d);
    @(negedge clk);
    case (which)
      0: cpu_rx_rd = 1;
      1: begin cpu_tx_wr = 1; cpu_tx_wdata = d; end
      2: instr_done = 1;
      default: halt_enter = 1;
    endcase
    @(negedge clk);
    cpu_rx_rd = 0; cpu_tx_wr = 0; instr_done = 0; halt_enter = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    nerr++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 pready", pready, 1);
    chk("R1 fetch", instr_fetch, 0);
    stat("R1 status", 8'h24);

    for (int m = 0; m < 3; m++) begin
      apb(1, 2'd0, 8'(m << 6), rd);
      stat("R2 mode", stv(0,0,1,0,0,1,2'(m)));
    end
    apb(1, 2'd0, 8'hC0, rd);
    stat("R2 reserved ignored", stv(0,0,1,0,0,1,2'd2));
    apb(1, 2'd0, 8'h00, rd);

    base = fetch_cnt;
    apb(1, 2'd1, 8'hA1, rd);
    chk("R4 write", cpu_rx_data, 8'hA1);
    apb(1, 2'd1, 8'hB2, rd);
    chk("R4 drop", cpu_rx_data, 8'hA1);
    stat("R3 status", stv(1,0,1,1,0,1,0));
    strobe(0, 0);
    stat("R9 rx read", stv(0,0,1,1,0,1,0));
    settle();
    chk("R8 no fetch in mode 00", fetch_cnt, base);
    for (int v = 0; v < 16; v++) begin
      logic [DW-1:0] d;
      d = 8'(v * 37 + 5);
      apb(1, 2'd1, d, rd);
      chk("R4 sweep", cpu_rx_data, d);
      strobe(0, 0);
      stat("R3 sweep", stv(0,0,1,1,0,1,0));
    end

    apb(0, 2'd2, '0, rd);
    stat("R5 drop", stv(0,0,1,0,0,1,0));
    strobe(1, 8'h11);
    strobe(1, 8'h22);
    apb(0, 2'd2, '0, rd);
    stat("R5 drop keeps full", stv(0,1,1,0,0,1,0));
    apb(0, 2'd2, '0, rd);
    chk("R9 overwrite", rd, 8'h22);
    stat("R5 clears", stv(0,0,1,0,0,1,0));

    base = fetch_cnt;
    apb(1, 2'd3, 8'h7E, rd);
    settle();
    chk("R6 fetch", fetch_cnt, base + 1);
    chk("R6 word", instr_word, 8'h7E);
    apb(1, 2'd3, 8'h55, rd);
    settle();
    chk("R6 drop word", instr_word, 8'h7E);
    chk("R6 drop fetch", fetch_cnt, base + 1);
    stat("R6 flags", stv(0,0,0,0,0,0,0));
    strobe(2, 0);
    stat("R10 done", stv(0,0,1,0,0,0,0));
    apb(1, 2'd3, 8'h55, rd);
    settle();
    chk("R6 word2", instr_word, 8'h55);
    chk("R6 fetch2", fetch_cnt, base + 2);
    strobe(3, 0);
    stat("R10 halt", stv(0,0,0,0,0,1,0));
    strobe(2, 0);
    stat("R10 sync", stv(0,0,1,0,0,0,0));

    apb(1, 2'd0, 8'h40, rd);
    base = fetch_cnt;
    apb(1, 2'd1, 8'hC3, rd);
    fork
      apb(1, 2'd1, 8'h3C, rd);
      begin
        repeat (3) @(negedge clk); #2;
        chk("R7 rx stalled", pready, 0);
        @(negedge clk); cpu_rx_rd = 1; #2;
        chk("R7 rx release", pready, 1);
        chk("R9 core sees old", cpu_rx_data, 8'hC3);
        @(negedge clk); cpu_rx_rd = 0;
      end
    join
    chk("R7 rx data", cpu_rx_data, 8'h3C);
    fork
      apb(0, 2'd2, '0, rd);
      begin
        repeat (3) @(negedge clk); #2;
        chk("R7 tx stalled", pready, 0);
        @(negedge clk); cpu_tx_wr = 1; cpu_tx_wdata = 8'h5A; #2;
        chk("R7 tx release", pready, 1);
        @(negedge clk); cpu_tx_wr = 0;
      end
    join
    chk("R7 tx bypass", rd, 8'h5A);
    stat("R7 flags", stv(1,0,1,1,0,1,2'd1));
    apb(1, 2'd3, 8'h90, rd);
    fork
      apb(1, 2'd3, 8'h91, rd);
      begin
        repeat (3) @(negedge clk); #2;
        chk("R7 it stalled", pready, 0);
        @(negedge clk); instr_done = 1; #2;
        chk("R7 it release", pready, 1);
        @(negedge clk); instr_done = 0;
      end
    join
    settle();
    chk("R7 it word", instr_word, 8'h91);
    chk("R8 stall fetches", fetch_cnt, base + 2);
    strobe(2, 0);

    apb(1, 2'd0, 8'h80, rd);
    strobe(0, 0);
    base = fetch_cnt;
    apb(1, 2'd1, 8'h44, rd);
    settle();
    chk("R8 fast rx fetch", fetch_cnt, base + 1);
    strobe(2, 0);
    strobe(1, 8'h66);
    apb(0, 2'd2, '0, rd);
    chk("R8 fast tx data", rd, 8'h66);
    settle();
    chk("R8 fast tx fetch", fetch_cnt, base + 2);
    stat("R8 flags", stv(1,0,0,1,0,0,2'd2));
    chk("R6 pulse width", wide, 0);
    finish_run();
  end
endmodule